// File: doc/BRIEF.md
# Write-back write-allocate data cache

This block is the data cache for the memory stage of a simple in-order processor. Each cycle the stage may present one word-sized, word-aligned load or store. The cache looks up a direct-mapped array of 128 lines. Each line holds 32 bytes, so the array holds 4 KiB of data. A load hit returns the word in the same cycle. A store hit changes only the cached copy. In neither case does the cache touch external memory.

On a miss the cache raises `stall`, and the whole pipeline freezes with the request held steady on the inputs. The cache then drives a byte-wide external memory. If the line it is about to replace is valid, that line is written back first. The line holds no modified flag, so a clean line is also written back. The cache then reads the new line and returns to idle. At that point the held request is a hit. A load returns its word and a store merges into the freshly filled line.

Each transfer opens with a one-cycle command and its block address. The memory answers with one `mem_beat` per byte, in ascending byte order. The stall releases in the cycle after the last beat of the fill.

Top module: `dcache_wb`

## Requirements
- R1: After reset, `stall` is low while no request is presented and `mem_cmd` is 0 (idle). Every line is invalid, so the first access to any address misses and produces only a read command.
- R2: A load that hits drives `rsp_rdata` with the stored word and keeps `stall` low in the same cycle, with no memory command. Byte lane b of a word (bits 8b+7..8b) is the byte at word address + b.
- R3: A store that hits replaces the cached word without any memory command, and a later load of that address returns the stored data.
- R4: The request address splits into index bits 11..5 and tag bits 31..12. A miss on an invalid line issues a single read command (`mem_cmd` = 1) whose address is the request address with bits 4..0 cleared. Let L be the number of idle cycles the memory leaves between a command and its first beat. `stall` is high for exactly L+34 cycles, and the requested word is then returned.
- R5: A miss on a valid line first issues a write command (`mem_cmd` = 2) at the victim address {stored tag, index, 5'b0}. This happens whether or not the line was modified. It sends the line's 32 bytes over `mem_wdata` in ascending offset order and then issues the read of R4. `stall` is high for exactly 2L+67 cycles.
- R6: A store miss fills the target line from memory and then overwrites the addressed word. The other words of the line keep the values read from memory.
- R7: `stall` is high in every cycle that carries a memory command or a transfer beat. It falls only in the cycle right after a beat.
- R8: Every memory command lasts exactly one cycle, and exactly 32 beats occur between two consecutive commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load or store is presented |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| rsp_rdata | output | 32 | Load data, valid while `stall` is low |
| stall | output | 1 | Freezes the pipeline during a miss |
| mem_cmd | output | 2 | 0 idle, 1 read block, 2 write block; one-cycle pulse |
| mem_addr | output | 32 | Block base address of the current transfer |
| mem_wdata | output | 8 | Write-back byte for the next beat |
| mem_rdata | input | 8 | Fill byte, valid with `mem_beat` |
| mem_beat | input | 1 | Memory moves one byte this cycle |

## Verification
The bound checker watches the memory handshake on every cycle:
- commands are single-cycle pulses;
- `stall` covers every command and beat;
- `stall` can drop only right after a beat;
- a counter confirms 32 beats between commands.

Only the bench scenarios can show the following:
- load data after a hit or a refill matches the architectural memory contents;
- a store merges into a filled line;
- the victim line, including an unmodified one, is written back with the right bytes to the right address;
- the stall lasts exactly the predicted number of cycles for each of the four access cases.

// File: rtl/dcw_pkg.sv
`timescale 1ns/1ps
package dcw_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } mem_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WB_REQ,
      ST_WB_RUN,
      ST_FL_REQ,
      ST_FL_RUN
   } miss_st_e;
endpackage

// File: rtl/dcw_tag_store.sv
`timescale 1ns/1ps
module dcw_tag_store #(
   parameter int LINES = 128,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [TAG_W-1:0] set_tag,
   output logic             hit,
   output logic             vic_valid,
   output logic [TAG_W-1:0] vic_tag
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (set_en)
         valid_q[set_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (set_en)
         tag_q[set_idx] <= set_tag;
   end

   assign vic_valid = valid_q[lk_idx];
   assign vic_tag   = tag_q[lk_idx];
   assign hit       = vic_valid && (vic_tag == lk_tag);
endmodule

// File: rtl/dcw_data_store.sv
`timescale 1ns/1ps
module dcw_data_store #(
   parameter int LINES  = 128,
   parameter int WPL    = 8,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int WI_W  = $clog2(LINES * WPL),
   localparam int LANES = DATA_W / LANE_W,
   localparam int LN_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic [WI_W-1:0]   rd_widx,
   output logic [DATA_W-1:0] rd_word,
   input  logic [WI_W-1:0]   wb_widx,
   input  logic [LN_W-1:0]   wb_lane,
   output logic [LANE_W-1:0] wb_byte,
   input  logic              wr_en,
   input  logic [WI_W-1:0]   wr_widx,
   input  logic [DATA_W-1:0] wr_word,
   input  logic              fl_en,
   input  logic [WI_W-1:0]   fl_widx,
   input  logic [LN_W-1:0]   fl_lane,
   input  logic [LANE_W-1:0] fl_byte
);
   logic [DATA_W-1:0] words_q [LINES*WPL];
   logic [DATA_W-1:0] wb_word;

   always_ff @(posedge clk) begin
      if (wr_en)
         words_q[wr_widx] <= wr_word;
      if (fl_en)
         words_q[fl_widx][fl_lane*LANE_W +: LANE_W] <= fl_byte;
   end

   assign rd_word = words_q[rd_widx];
   assign wb_word = words_q[wb_widx];
   assign wb_byte = wb_word[wb_lane*LANE_W +: LANE_W];
endmodule

// File: rtl/dcw_miss_fsm.sv
`timescale 1ns/1ps
module dcw_miss_fsm
   import dcw_pkg::*;
#(
   parameter int BEATS = 32,
   localparam int CNT_W = $clog2(BEATS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss,
   input  logic             vic_valid,
   input  logic             mem_beat,
   output miss_st_e         state_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o,
   output mem_cmd_e         cmd_o
);
   miss_st_e         st_q, st_d;
   logic [CNT_W-1:0] cnt_q;

   assign last_o = mem_beat && (cnt_q == CNT_W'(BEATS - 1));

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:   if (miss) st_d = vic_valid ? ST_WB_REQ : ST_FL_REQ;
         ST_WB_REQ: st_d = ST_WB_RUN;
         ST_WB_RUN: if (last_o) st_d = ST_FL_REQ;
         ST_FL_REQ: st_d = ST_FL_RUN;
         ST_FL_RUN: if (last_o) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_WB_REQ || st_q == ST_FL_REQ)
            cnt_q <= '0;
         else if (mem_beat && (st_q == ST_WB_RUN || st_q == ST_FL_RUN))
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_comb begin
      case (st_q)
         ST_WB_REQ: cmd_o = CMD_WRITE;
         ST_FL_REQ: cmd_o = CMD_READ;
         default:   cmd_o = CMD_IDLE;
      endcase
   end

   assign state_o = st_q;
   assign cnt_o   = cnt_q;
endmodule

// File: rtl/dcache_wb.sv
`timescale 1ns/1ps
module dcache_wb
   import dcw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int LINES       = 128,
   parameter int BLOCK_BYTES = 32,
   parameter int MEM_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              stall,
   output logic [1:0]        mem_cmd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [MEM_W-1:0]  mem_wdata,
   input  logic [MEM_W-1:0]  mem_rdata,
   input  logic              mem_beat
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OFF_W      = $clog2(BLOCK_BYTES);
   localparam int IDX_W      = $clog2(LINES);
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
   localparam int WPL        = BLOCK_BYTES / WORD_BYTES;
   localparam int WSEL_W     = $clog2(WPL);
   localparam int LSEL_W     = $clog2(WORD_BYTES);
   localparam int BEATS      = BLOCK_BYTES * 8 / MEM_W;
   localparam int CNT_W      = $clog2(BEATS);

   generate
      if (MEM_W != 8) begin : g_bad_mem_w
         $error("memory port must be one byte wide");
      end
      if ((1 << OFF_W) != BLOCK_BYTES || (1 << IDX_W) != LINES) begin : g_bad_pow2
         $error("block size and line count must be powers of two");
      end
      if (DATA_W % 8 != 0 || WORD_BYTES < 2 || WPL < 2) begin : g_bad_word
         $error("a block must hold at least two multi-byte words");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("address too narrow for the chosen geometry");
      end
   endgenerate

   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [WSEL_W-1:0] req_wsel;
   logic              addr_unused;

   assign req_tag     = req_addr[ADDR_W-1 -: TAG_W];
   assign req_idx     = req_addr[OFF_W +: IDX_W];
   assign req_wsel    = req_addr[LSEL_W +: WSEL_W];
   assign addr_unused = ^req_addr[LSEL_W-1:0];

   logic             hit, vic_valid, busy, miss, last_beat;
   logic [TAG_W-1:0] vic_tag;
   miss_st_e         st;
   mem_cmd_e         cmd;
   logic [CNT_W-1:0] cnt;

   logic [IDX_W-1:0] lat_idx;
   logic [TAG_W-1:0] lat_tag, lat_vtag;

   assign busy  = (st != ST_IDLE);
   assign miss  = req_valid && !hit && !busy;
   assign stall = busy || (req_valid && !hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_idx  <= '0;
         lat_tag  <= '0;
         lat_vtag <= '0;
      end else if (miss) begin
         lat_idx  <= req_idx;
         lat_tag  <= req_tag;
         lat_vtag <= vic_tag;
      end
   end

   dcw_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (req_idx),
      .lk_tag   (req_tag),
      .set_en   (st == ST_FL_RUN && last_beat),
      .set_idx  (lat_idx),
      .set_tag  (lat_tag),
      .hit      (hit),
      .vic_valid(vic_valid),
      .vic_tag  (vic_tag)
   );

   dcw_miss_fsm #(.BEATS(BEATS)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .miss     (miss),
      .vic_valid(vic_valid),
      .mem_beat (mem_beat),
      .state_o  (st),
      .cnt_o    (cnt),
      .last_o   (last_beat),
      .cmd_o    (cmd)
   );

   dcw_data_store #(.LINES(LINES), .WPL(WPL), .DATA_W(DATA_W), .LANE_W(MEM_W)) u_data (
      .clk    (clk),
      .rd_widx({req_idx, req_wsel}),
      .rd_word(rsp_rdata),
      .wb_widx({lat_idx, cnt[CNT_W-1:LSEL_W]}),
      .wb_lane(cnt[LSEL_W-1:0]),
      .wb_byte(mem_wdata),
      .wr_en  (req_valid && req_write && hit && !busy),
      .wr_widx({req_idx, req_wsel}),
      .wr_word(req_wdata),
      .fl_en  (st == ST_FL_RUN && mem_beat),
      .fl_widx({lat_idx, cnt[CNT_W-1:LSEL_W]}),
      .fl_lane(cnt[LSEL_W-1:0]),
      .fl_byte(mem_rdata)
   );

   assign mem_cmd  = cmd;
   assign mem_addr = (st == ST_WB_REQ || st == ST_WB_RUN) ?
                     {lat_vtag, lat_idx, OFF_W'(0)} : {lat_tag, lat_idx, OFF_W'(0)};
endmodule

// File: rtl/dcache_wb_chk.sv
`timescale 1ns/1ps
module dcache_wb_chk #(
   parameter int BEATS = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic       stall,
   input logic       mem_beat,
   input logic [1:0] mem_cmd
);
   localparam int BC_W = $clog2(BEATS + 1) + 1;

   logic [BC_W-1:0] beat_cnt;
   logic            seen_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_cnt <= '0;
         seen_cmd <= 1'b0;
      end else if (mem_cmd != 2'd0) begin
         beat_cnt <= '0;
         seen_cmd <= 1'b1;
      end else if (mem_beat) begin
         beat_cnt <= beat_cnt + BC_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      // R1
      if (!rst_n) reset_cmd_chk: assert (mem_cmd == 2'd0);
   end

   // R8
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd != 2'd0) |=> (mem_cmd == 2'd0));

   // R7
   cmd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd != 2'd0) |-> stall);

   // R7
   beat_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_beat |-> stall);

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> $past(mem_beat));

   // R8
   beats_per_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd != 2'd0 && seen_cmd) |-> (beat_cnt == BC_W'(BEATS)));

   // R8
   beat_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_cnt <= BC_W'(BEATS));
endmodule

bind dcache_wb dcache_wb_chk #(.BEATS(BLOCK_BYTES * 8 / MEM_W)) u_chk (.*);

// File: tb/sim_dcache_wb.sv
`timescale 1ns/1ps
module sim_dcache_wb;
   localparam int L = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [31:0] rsp_rdata, mem_addr;
   logic        stall, mem_beat = 1'b0;
   logic [1:0]  mem_cmd;
   logic [7:0]  mem_wdata, mem_rdata = '0;

   int vectors = 0, fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   dcache_wb u0 (.*);

   logic [7:0]  bmem   [bit [31:0]];
   logic [7:0]  refmem [bit [31:0]];
   logic [33:0] cmdq [$];
   bit          rv [128];
   logic [19:0] rt [128];

   function automatic logic [7:0] init_b(input logic [31:0] a);
      logic [31:0] t;
      t = a * 32'd5 + (a >> 8) + 32'd1;
      return t[7:0];
   endfunction
   function automatic logic [7:0] bm_rd(input logic [31:0] a);
      return bmem.exists(a) ? bmem[a] : init_b(a);
   endfunction
   function automatic logic [7:0] ref_rd(input logic [31:0] a);
      return refmem.exists(a) ? refmem[a] : init_b(a);
   endfunction
   function automatic logic [31:0] ref_word(input logic [31:0] a);
      return {ref_rd(a + 3), ref_rd(a + 2), ref_rd(a + 1), ref_rd(a)};
   endfunction

   task automatic check(input bit ok, input string r, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   // behavioural byte-wide memory: L idle cycles after a command, then 32 beats
   bit          m_busy = 0;
   bit          m_wr = 0;
   int          m_wait = 0, m_k = 0;
   logic [31:0] m_base = '0;
   always @(negedge clk) begin
      mem_beat = 1'b0;
      if (!rst_n) m_busy = 0;
      else if (m_busy) begin
         if (m_wait > 0) m_wait--;
         else begin
            mem_beat  = 1'b1;
            mem_rdata = bm_rd(m_base + m_k);
            if (m_wr) bmem[m_base + m_k] = mem_wdata;
            m_k++;
            if (m_k == 32) m_busy = 0;
         end
      end else if (mem_cmd != 2'd0) begin
         cmdq.push_back({mem_cmd, mem_addr});
         m_busy = 1; m_wr = (mem_cmd == 2'd2);
         m_base = mem_addr; m_wait = L; m_k = 0;
      end
   end

   task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         input string r);
      logic [6:0]  idx;
      logic [19:0] tg;
      logic [31:0] blk, vaddr;
      bit          hit, dirty;
      int          exp, ncmd, bad;
      logic [33:0] c;
      idx = a[11:5]; tg = a[31:12]; blk = {a[31:5], 5'b0};
      hit = rv[idx] && rt[idx] == tg;
      dirty = !hit && rv[idx];
      vaddr = {rt[idx], idx, 5'b0};
      exp = hit ? 0 : dirty ? 2 * L + 67 : L + 34;
      ncmd = hit ? 0 : dirty ? 2 : 1;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      for (int i = 0; i <= exp; i++) begin
         #1;
         check(stall == (i < exp), r, $sformatf("stall cycle %0d", i),
               32'(stall), 32'(i < exp));
         if (i < exp) @(negedge clk);
      end
      if (!wr) check(rsp_rdata == ref_word(a), r, "load data", rsp_rdata, ref_word(a));
      check(cmdq.size() == ncmd, r, "command count", cmdq.size(), ncmd);
      if (dirty && cmdq.size() > 0) begin
         c = cmdq.pop_front();
         check(c == {2'd2, vaddr}, r, "write-back command", c[31:0], vaddr);
      end
      if (!hit && cmdq.size() > 0) begin
         c = cmdq.pop_front();
         check(c == {2'd1, blk}, r, "fill command", c[31:0], blk);
      end
      cmdq.delete();
      if (dirty) begin
         bad = 0;
         for (int k = 0; k < 32; k++)
            if (bm_rd(vaddr + k) !== ref_rd(vaddr + k)) bad++;
         check(bad == 0, "R5", "written-back bytes wrong", bad, 0);
      end
      rv[idx] = 1; rt[idx] = tg;
      if (wr)
         for (int b = 0; b < 4; b++) refmem[a + b] = d[8*b +: 8];
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) begin rv[i] = 0; rt[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: idle after reset
      check(stall == 1'b0, "R1", "stall after reset", 32'(stall), 0);
      check(mem_cmd == 2'd0, "R1", "command after reset", 32'(mem_cmd), 0);
      // R1 R4: first access is a clean miss
      do_req(0, 32'h0000_0040, 0, "R4");
      // R2: hits in the filled line
      do_req(0, 32'h0000_0044, 0, "R2");
      do_req(0, 32'h0000_005C, 0, "R2");
      // R3: store hit, then read back
      do_req(1, 32'h0000_0048, 32'hDEAD_BEEF, "R3");
      do_req(0, 32'h0000_0048, 0, "R3");
      // R5: conflicting tag evicts the modified line
      do_req(0, 32'h0000_1048, 0, "R5");
      // R5: bring the old line back, stored data must round-trip
      do_req(0, 32'h0000_0048, 0, "R5");
      // R6: store miss on an invalid line, then neighbours keep memory values
      do_req(1, 32'h0000_2064, 32'h1234_5678, "R6");
      do_req(0, 32'h0000_2060, 0, "R6");
      do_req(0, 32'h0000_2064, 0, "R6");
      // R6 R5: store miss with valid victim
      do_req(1, 32'h0000_3064, 32'hCAFE_F00D, "R6");
      do_req(0, 32'h0000_3064, 0, "R6");
      // R4: last line, last word of block
      do_req(0, 32'h0000_0FFC, 0, "R4");
      do_req(0, 32'h0000_0FE0, 0, "R2");
      // R5: unmodified victim is still written back; top of address space
      do_req(0, 32'hFFFF_FFFC, 0, "R5");
      // R7 R8: back-to-back misses
      do_req(1, 32'h0000_2060, 32'h0BAD_CAFE, "R7");
      do_req(0, 32'h0000_2060, 0, "R8");
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(stall == 1'b0, "R1", "stall with no request", 32'(stall), 0);
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule